// File: doc/BRIEF.md
# SPI Boot Receive Word Packer

This block is the receive side of a serial boot loader. A host streams boot data over SPI as a continuous bit stream, with no gaps, and its word width is 8, 16 or 32 bits. The block samples the serial clock, data and select lines in the system clock domain. It finds rising edges of the serial clock and shifts the data into host-sized words. It then packs those words into a fixed 32-bit word for the boot DMA.

Narrow host words go in least-significant-word first. The first byte or halfword of each group lands in the low bits of the 32-bit word, and later ones fill the higher positions. Each completed word is shown on `word_data` together with a one-cycle `word_valid` strobe. When chip select goes inactive, any bits already received are dropped and the bit and slot counters restart. The width select is taken into the block only while chip select is inactive, so a frame always keeps the width it started with.

Top module: `spi_boot_packer`

## Requirements
- R1: After a synchronous reset, `word_valid` is 0 and `word_data` is 0.
- R2: With `host_width` = 2 (or 3), each 32 serial bits form one output word, with the first bit received in bit 31.
- R3: With `host_width` = 1, two 16-bit host words form one output word. Each halfword is received MSB first, the first halfword goes in bits 15:0 and the second in bits 31:16.
- R4: With `host_width` = 0, four bytes form one output word. Each byte is received MSB first, and the first byte goes in bits 7:0, up to the fourth byte in bits 31:24. For example, the bytes 0x66, 0x55, 0x44, 0x33 give 0x33445566.
- R5: Bits that arrive back to back across host-word and output-word boundaries are all captured. For example, 96 continuous bits in 8-bit mode give exactly three output words.
- R6: `word_valid` is high for exactly one system clock cycle per completed word.
- R7: When chip select is deasserted with a partial word pending, no word is produced. The next frame starts a new word at bit 0 of slot 0.
- R8: A change of `host_width` while chip select is asserted has no effect on the current frame. The new width applies from the next frame.
- R9: `word_data` keeps the last delivered word until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host; data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Chip select, active low |
| host_width | input | 2 | Host word width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| word_valid | output | 1 | One-cycle strobe marking a new packed word |
| word_data | output | 32 | Packed 32-bit word |

## Verification
A bit counter that is off by one shows up at the ports within the next output word. The halves or bytes of that word come out rotated or shifted. A slot counter that is wrong puts host words in the wrong lanes of the very next strobe, or produces a strobe too early or too late. Counters that are not cleared when chip select goes inactive show up in the first word of the following frame, which then arrives after the wrong number of bits. A width register that follows `host_width` in the middle of a frame changes the packing of the word that is being assembled at that moment.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

  typedef enum logic [1:0] {
    HW_8   = 2'd0,
    HW_16  = 2'd1,
    HW_32  = 2'd2,
    HW_32X = 2'd3
  } host_w_e;

  function automatic int unsigned host_bits(input host_w_e m);
    case (m)
      HW_8:    return 8;
      HW_16:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign sync_out[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_pack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_act,
  input  host_w_e           mode,
  output logic              hw_valid,
  output logic [WORD_W-1:0] hw_data
);

  logic              sclk_d;
  logic              rise;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise    = sclk_s & ~sclk_d;
  assign limit   = CNT_W'(host_bits(mode) - 1);
  assign sh_next = {sh[WORD_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cnt      <= '0;
      sh       <= '0;
      hw_valid <= 1'b0;
      if (rst) hw_data <= '0;
    end else begin
      hw_valid <= 1'b0;
      if (rise) begin
        if (cnt == limit) begin
          cnt      <= '0;
          sh       <= '0;
          hw_valid <= 1'b1;
          hw_data  <= sh_next;
        end else begin
          cnt <= cnt + 1'b1;
          sh  <= sh_next;
        end
      end
    end
  end

  // R5: the bit counter never passes the end of a host word
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);

  // R7: an idle select leaves no bit count and no host word behind
  a_r7_shift_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0 && !hw_valid));

endmodule

// File: rtl/spi_lsw_packer.sv
module spi_lsw_packer
  import spi_pack_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SLOT_W = $clog2(WORD_W / 8),
  localparam int unsigned SH_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  host_w_e           mode,
  input  logic              hw_valid,
  input  logic [WORD_W-1:0] hw_data,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] last_slot;
  logic [SH_W-1:0]   lane_sh;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;

  always_comb begin
    case (mode)
      HW_8: begin
        last_slot = SLOT_W'(WORD_W / 8 - 1);
        lane_sh   = SH_W'({slot, 3'b000});
      end
      HW_16: begin
        last_slot = SLOT_W'(WORD_W / 16 - 1);
        lane_sh   = SH_W'({slot[0], 4'b0000});
      end
      default: begin
        last_slot = '0;
        lane_sh   = '0;
      end
    endcase
  end

  assign merged = acc | (hw_data << lane_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= '0;
      acc        <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!cs_act) begin
        slot <= '0;
        acc  <= '0;
      end else if (hw_valid) begin
        if (slot == last_slot) begin
          slot       <= '0;
          acc        <= '0;
          word_valid <= 1'b1;
          word_data  <= merged;
        end else begin
          slot <= slot + 1'b1;
          acc  <= merged;
        end
      end
    end
  end

  // R6: a strobe never lasts two cycles
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R7: an idle select restarts packing at slot 0
  a_r7_slot_idle: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> slot == '0);

  // R9: data holds between strobes
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_data));

  // R5: the last host word of a group yields a strobe next cycle
  a_r5_group_strobe: assert property (@(posedge clk) disable iff (rst)
    (cs_act && hw_valid && slot == last_slot) |=> word_valid);

endmodule

// File: rtl/spi_boot_packer.sv
module spi_boot_packer
  import spi_pack_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  input  logic [1:0]        host_width,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);

  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              mosi_s;
  logic              cs_act;
  host_w_e           mode_q;
  logic              hw_valid;
  logic [WORD_W-1:0] hw_data;

  spi_in_sync #(
    .N       (3),
    .STAGES  (SYNC_DEPTH),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({spi_cs_n, spi_mosi, spi_sclk}),
    .sync_out (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign mosi_s = pins_s[1];
  assign cs_act = ~pins_s[2];

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= HW_32;
    else if (!cs_act) mode_q <= host_w_e'(host_width);
  end

  // R8: the width in use is frozen while a frame is active
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    cs_act |=> $stable(mode_q));

  spi_host_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sclk_s),
    .mosi_s   (mosi_s),
    .cs_act   (cs_act),
    .mode     (mode_q),
    .hw_valid (hw_valid),
    .hw_data  (hw_data)
  );

  spi_lsw_packer #(.WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .mode       (mode_q),
    .hw_valid   (hw_valid),
    .hw_data    (hw_data),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

endmodule

// File: tb/test_spi_boot_packer.sv
module test_spi_boot_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic [1:0]  host_width = 2'd2;
  logic        word_valid;
  logic [31:0] word_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_word = '0;
  logic        prev_valid = 1'b0;

  always #5 clk = ~clk;

  spi_boot_packer i_spi_boot_packer (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .host_width(host_width),
    .word_valid(word_valid), .word_data(word_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    tag_q.push_back(tag);
    last_word = w;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = v[i];
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_on;
    spi_cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic frame_off;
    repeat (12) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // monitor: compare each strobe against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        total++;
        if (prev_valid) begin
          bad++;
          $display("FAIL R6: actual=valid two cycles expected=one cycle");
        end
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R7: actual=unexpected word %h expected=no word", word_data);
        end else begin
          check(tag_q.pop_front(), word_data, exp_q.pop_front());
        end
      end
      prev_valid = word_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] acc;
    logic [7:0]  b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", {31'd0, word_valid}, 32'd0);
    check("R1 data", word_data, 32'd0);

    // R2: 32-bit host, two words in one frame
    host_width = 2'd2;
    repeat (4) @(negedge clk);
    frame_on;
    expect_word(32'hA5C31E0F, "R2 word0");
    send_bits(32'hA5C31E0F, 32);
    expect_word(32'h12345678, "R2 word1");
    send_bits(32'h12345678, 32);
    frame_off;
    check("R9 hold", word_data, last_word);

    // R4: 8-bit host, first byte low
    host_width = 2'd0;
    repeat (4) @(negedge clk);
    frame_on;
    expect_word(32'h33445566, "R4 example");
    send_bits(32'h66, 8); send_bits(32'h55, 8);
    send_bits(32'h44, 8); send_bits(32'h33, 8);
    expect_word(32'h7E81F00F, "R4 word1");
    send_bits(32'h0F, 8); send_bits(32'hF0, 8);
    send_bits(32'h81, 8); send_bits(32'h7E, 8);
    frame_off;

    // R3: 16-bit host, first halfword low
    host_width = 2'd1;
    repeat (4) @(negedge clk);
    frame_on;
    expect_word(32'h33445566, "R3 word0");
    send_bits(32'h5566, 16); send_bits(32'h3344, 16);
    expect_word(32'hDEADBEEF, "R3 word1");
    send_bits(32'hBEEF, 16); send_bits(32'hDEAD, 16);
    frame_off;
    check("R9 hold", word_data, last_word);

    // R5: 96 continuous bits in 8-bit mode give three words
    host_width = 2'd0;
    repeat (4) @(negedge clk);
    frame_on;
    for (int w = 0; w < 3; w++) begin
      acc = '0;
      for (int k = 0; k < 4; k++) begin
        b = 8'(8'h13 * (w * 4 + k) + 8'h29);
        acc = acc | (32'(b) << (8 * k));
      end
      expect_word(acc, "R5 stream");
    end
    for (int w = 0; w < 3; w++)
      for (int k = 0; k < 4; k++)
        send_bits(32'(8'(8'h13 * (w * 4 + k) + 8'h29)), 8);
    frame_off;

    // R7: partial word dropped, next frame realigned
    frame_on;
    send_bits(32'hAA, 8); send_bits(32'hBB, 8); send_bits(32'hCC, 8);
    frame_off;
    check("R7 no word", 32'(exp_q.size()), 32'd0);
    check("R7 data kept", word_data, last_word);
    frame_on;
    expect_word(32'h04030201, "R7 realign");
    send_bits(32'h01, 8); send_bits(32'h02, 8);
    send_bits(32'h03, 8); send_bits(32'h04, 8);
    frame_off;

    // R8: width change mid-frame ignored, applied next frame
    frame_on;
    expect_word(32'hD4C3B2A1, "R8 mid-frame");
    send_bits(32'hA1, 8); send_bits(32'hB2, 8);
    host_width = 2'd2;
    send_bits(32'hC3, 8); send_bits(32'hD4, 8);
    frame_off;
    frame_on;
    expect_word(32'hCAFEF00D, "R8 next frame");
    send_bits(32'hCAFEF00D, 32);
    frame_off;

    // R2 via code 3
    host_width = 2'd3;
    repeat (4) @(negedge clk);
    frame_on;
    expect_word(32'h0BADC0DE, "R2 code3");
    send_bits(32'h0BADC0DE, 32);
    frame_off;
    check("R9 hold", word_data, last_word);

    check("R5 all delivered", 32'(exp_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule